// File: doc/BRIEF.md
# Vector Lane Predicate Mask Unit

This block decides which byte lanes of a 128-bit vector datapath may be written by the vector instruction that is executing now. It also holds the predication state that produces that decision. The state has three parts: a 16-bit per-lane predicate, two 4-bit block-mask fields (one for the low eight lanes, one for the high eight), and a beat-skip code. The beat-skip code records how much of a partly executed instruction has already completed. The lane mask is built combinationally from three sources, applied in this order:

- block predication, which takes the predicate and opens a half fully when its block field is zero;
- trimming on the last loop iteration, driven by the element-size code and the loop counter;
- removal of beats that have already executed, applied only when the condition nibble is zero.

Bit i of the mask enables byte lane i. Operations on 16-bit elements read the even bits of the mask, and operations on 32-bit elements read bits 0, 4, 8 and 12.

A load strobe from the issue stage writes a new predication state. A retire strobe advances the state once the instruction completes. On retire, the beat-skip code collapses, each half of the predicate whose block field selects an else-slot is inverted, and both block fields shift left by one.

Top module: `vpm_lane_pred_unit`

## Requirements
- R1: With tail trimming and beat removal inactive, lane_mask equals p0_q, except that lanes 7:0 are all 1 when blk_lo_q is zero and lanes 15:8 are all 1 when blk_hi_q is zero.
- R2: When tail_size is below 4 and loop_cnt is at most 16 >> tail_size, only the lowest (loop_cnt << tail_size) bits of the R1 mask are kept and all higher bits are cleared; a loop_cnt of zero clears every bit.
- R3: The beat-skip code is 0 none, 1 first beat done, 2 two beats done, 3 three beats done, 4 three beats plus one of the next instruction done. It is applied only when cond_nib is zero: code 1 clears mask bits 3:0, code 2 clears bits 7:0, and codes 3 and 4 clear bits 11:0. Codes above 4 are illegal. When cond_nib is nonzero, the beat-skip code has no effect on the mask.
- R4: On retire with cond_nib zero, skip_q becomes 1 if it was 4 and becomes 0 otherwise. With cond_nib nonzero, skip_q is unchanged.
- R5: On retire with both block fields zero, p0_q and both block fields are unchanged.
- R6: On retire, when a block field is between 9 and 15 inclusive, the matching byte half of p0_q (7:0 for low, 15:8 for high) is inverted. A field of exactly 8, or any value below 8, leaves that half unchanged.
- R7: On retire, when either block field is nonzero, each block field becomes its old value shifted left by one and truncated to 4 bits.
- R8: wr_en loads wr_p0, wr_blk_lo, wr_blk_hi and wr_skip on the next clock and takes priority over retire.
- R9: Synchronous reset clears p0_q, both block fields and skip_q. The resulting mask with tail and beat removal inactive is 0xFFFF.
- R10: With neither wr_en nor retire asserted, all state outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load new predication state |
| wr_p0 | input | 16 | Predicate value to load |
| wr_blk_lo | input | 4 | Low-half block field to load |
| wr_blk_hi | input | 4 | High-half block field to load |
| wr_skip | input | 3 | Beat-skip code to load (0..4) |
| retire | input | 1 | Current vector instruction completes |
| cond_nib | input | 4 | Condition nibble; zero enables beat-skip handling |
| tail_size | input | 3 | Element-size code; values 4 and above disable tail trimming |
| loop_cnt | input | 32 | Remaining loop element count |
| lane_mask | output | 16 | Byte-lane write enables |
| p0_q | output | 16 | Current predicate |
| blk_lo_q | output | 4 | Current low block field |
| blk_hi_q | output | 4 | Current high block field |
| skip_q | output | 3 | Current beat-skip code |

## Verification
The hardest state to reach from the ports is a retire where the block fields sit exactly on the else-slot boundary (8 versus 9 and above), combined with beat-skip code 4 and a zero condition nibble. In that state inversion, shifting and the skip collapse all act in the same edge. The bench first loads such states directly through the load port, then issues chains of back-to-back retires, so that fields walk through 8, 0 and the values above 8 by shifting alone. Tail trimming is driven with loop counts placed just below, at and above each element size's threshold, including zero.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
  typedef enum logic [2:0] {
    SKIP_NONE = 3'd0,
    SKIP_A    = 3'd1,
    SKIP_AB   = 3'd2,
    SKIP_ABC  = 3'd3,
    SKIP_ABCD = 3'd4
  } skip_e;
endpackage

// File: rtl/vpm_lane_mask.sv
module vpm_lane_mask
  import vpm_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int BLK_W  = 4,
  parameter int SKIP_W = 3,
  parameter int TSZ_W  = 3,
  parameter int CNT_W  = 32
) (
  input  logic [LANES-1:0]  p0,
  input  logic [BLK_W-1:0]  blk_lo,
  input  logic [BLK_W-1:0]  blk_hi,
  input  logic [SKIP_W-1:0] skip,
  input  logic [3:0]        cond_nib,
  input  logic [TSZ_W-1:0]  tail_size,
  input  logic [CNT_W-1:0]  loop_cnt,
  output logic [LANES-1:0]  mask
);
  localparam int HALF  = LANES / 2;
  localparam int BEATS = 4;
  localparam int BEAT  = LANES / BEATS;
  localparam int LOGL  = $clog2(LANES);

  logic [CNT_W-1:0] cnt_lim;
  logic [LOGL:0]    keep_len;
  logic             tail_on;
  logic             skip_on;
  int               n_done;
  logic [BEATS-1:0] beat_kill;
  logic [LANES-1:0] base;

  always_comb begin
    cnt_lim  = CNT_W'(LANES) >> tail_size;
    tail_on  = (int'(tail_size) < LOGL) && (loop_cnt <= cnt_lim);
    keep_len = loop_cnt[LOGL:0] << tail_size;
  end

  always_comb begin
    skip_on = (cond_nib == 4'd0);
    case (skip)
      SKIP_A:             n_done = 1;
      SKIP_AB:            n_done = 2;
      SKIP_ABC, SKIP_ABCD: n_done = 3;
      default:            n_done = 0;
    endcase
  end

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    assign beat_kill[b] = skip_on && (b < n_done);
  end

  always_comb begin
    base = p0;
    if (blk_lo == '0) base[HALF-1:0]     = '1;
    if (blk_hi == '0) base[LANES-1:HALF] = '1;
  end

  always_comb begin
    mask = base;
    for (int i = 0; i < LANES; i++) begin
      if (tail_on && (i >= int'(keep_len))) mask[i] = 1'b0;
      if (beat_kill[i / BEAT])              mask[i] = 1'b0;
    end
  end
endmodule

// File: rtl/vpm_next_state.sv
module vpm_next_state
  import vpm_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int BLK_W  = 4,
  parameter int SKIP_W = 3
) (
  input  logic [LANES-1:0]  p0,
  input  logic [BLK_W-1:0]  blk_lo,
  input  logic [BLK_W-1:0]  blk_hi,
  input  logic [SKIP_W-1:0] skip,
  input  logic [3:0]        cond_nib,
  output logic [LANES-1:0]  p0_nx,
  output logic [BLK_W-1:0]  blk_lo_nx,
  output logic [BLK_W-1:0]  blk_hi_nx,
  output logic [SKIP_W-1:0] skip_nx
);
  localparam int HALF = LANES / 2;

  logic active;
  logic flip_lo, flip_hi;

  // A field selects an else-slot when its top bit is set and it is not the terminator pattern.
  always_comb begin
    active  = (blk_lo != '0) || (blk_hi != '0);
    flip_lo = blk_lo[BLK_W-1] && (blk_lo[BLK_W-2:0] != '0);
    flip_hi = blk_hi[BLK_W-1] && (blk_hi[BLK_W-2:0] != '0);
  end

  always_comb begin
    if (cond_nib == 4'd0)
      skip_nx = (skip == SKIP_ABCD) ? SKIP_W'(SKIP_A) : SKIP_W'(SKIP_NONE);
    else
      skip_nx = skip;
  end

  always_comb begin
    p0_nx     = p0;
    blk_lo_nx = blk_lo;
    blk_hi_nx = blk_hi;
    if (active) begin
      if (flip_lo) p0_nx[HALF-1:0]     = ~p0[HALF-1:0];
      if (flip_hi) p0_nx[LANES-1:HALF] = ~p0[LANES-1:HALF];
      blk_lo_nx = {blk_lo[BLK_W-2:0], 1'b0};
      blk_hi_nx = {blk_hi[BLK_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/vpm_lane_pred_unit.sv
module vpm_lane_pred_unit #(
  parameter int LANES  = 16,
  parameter int BLK_W  = 4,
  parameter int SKIP_W = 3,
  parameter int TSZ_W  = 3,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_p0,
  input  logic [BLK_W-1:0]  wr_blk_lo,
  input  logic [BLK_W-1:0]  wr_blk_hi,
  input  logic [SKIP_W-1:0] wr_skip,
  input  logic              retire,
  input  logic [3:0]        cond_nib,
  input  logic [TSZ_W-1:0]  tail_size,
  input  logic [CNT_W-1:0]  loop_cnt,
  output logic [LANES-1:0]  lane_mask,
  output logic [LANES-1:0]  p0_q,
  output logic [BLK_W-1:0]  blk_lo_q,
  output logic [BLK_W-1:0]  blk_hi_q,
  output logic [SKIP_W-1:0] skip_q
);
  logic [LANES-1:0]  p0_nx;
  logic [BLK_W-1:0]  blk_lo_nx, blk_hi_nx;
  logic [SKIP_W-1:0] skip_nx;

  vpm_lane_mask #(
    .LANES(LANES), .BLK_W(BLK_W), .SKIP_W(SKIP_W), .TSZ_W(TSZ_W), .CNT_W(CNT_W)
  ) u_mask (
    .p0(p0_q), .blk_lo(blk_lo_q), .blk_hi(blk_hi_q), .skip(skip_q),
    .cond_nib(cond_nib), .tail_size(tail_size), .loop_cnt(loop_cnt),
    .mask(lane_mask)
  );

  vpm_next_state #(
    .LANES(LANES), .BLK_W(BLK_W), .SKIP_W(SKIP_W)
  ) u_next (
    .p0(p0_q), .blk_lo(blk_lo_q), .blk_hi(blk_hi_q), .skip(skip_q),
    .cond_nib(cond_nib),
    .p0_nx(p0_nx), .blk_lo_nx(blk_lo_nx), .blk_hi_nx(blk_hi_nx), .skip_nx(skip_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p0_q     <= '0;
      blk_lo_q <= '0;
      blk_hi_q <= '0;
      skip_q   <= '0;
    end else if (wr_en) begin
      p0_q     <= wr_p0;
      blk_lo_q <= wr_blk_lo;
      blk_hi_q <= wr_blk_hi;
      skip_q   <= wr_skip;
    end else if (retire) begin
      p0_q     <= p0_nx;
      blk_lo_q <= blk_lo_nx;
      blk_hi_q <= blk_hi_nx;
      skip_q   <= skip_nx;
    end
  end
endmodule

// File: rtl/vpm_lane_pred_chk.sv
module vpm_lane_pred_chk #(
  parameter int LANES  = 16,
  parameter int BLK_W  = 4,
  parameter int SKIP_W = 3,
  parameter int TSZ_W  = 3,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [LANES-1:0]  wr_p0,
  input logic [SKIP_W-1:0] wr_skip,
  input logic              retire,
  input logic [3:0]        cond_nib,
  input logic [LANES-1:0]  lane_mask,
  input logic [LANES-1:0]  p0_q,
  input logic [BLK_W-1:0]  blk_lo_q,
  input logic [BLK_W-1:0]  blk_hi_q,
  input logic [SKIP_W-1:0] skip_q
);
  localparam int HALF = LANES / 2;
  localparam int BEAT = LANES / 4;

  logic step;
  assign step = retire && !wr_en;

  // R3
  skip_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    skip_q <= SKIP_W'(4));

  // R3
  skip_load_legal_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_skip <= SKIP_W'(4));

  // R3
  three_beats_gone_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_nib == 4'd0 && skip_q >= SKIP_W'(3)) |-> lane_mask[3*BEAT-1:0] == '0);

  // R4
  skip_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && cond_nib == 4'd0 && skip_q == SKIP_W'(4)) |=> skip_q == SKIP_W'(1));

  // R4
  skip_collapse_chk: assert property (@(posedge clk) disable iff (rst)
    (step && cond_nib == 4'd0 && skip_q != SKIP_W'(4)) |=> skip_q == '0);

  // R5
  idle_pred_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step && blk_lo_q == '0 && blk_hi_q == '0) |=>
      (p0_q == $past(p0_q) && blk_lo_q == '0 && blk_hi_q == '0));

  // R6
  low_half_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (step && blk_lo_q[BLK_W-1] && blk_lo_q[BLK_W-2:0] != '0) |=>
      p0_q[HALF-1:0] == ~$past(p0_q[HALF-1:0]));

  // R7
  field_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (step && (blk_lo_q != '0 || blk_hi_q != '0)) |=>
      (blk_lo_q == BLK_W'($past(blk_lo_q) << 1) && blk_hi_q == BLK_W'($past(blk_hi_q) << 1)));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (p0_q == $past(wr_p0) && skip_q == $past(wr_skip)));

  // R10
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !retire) |=>
      ($stable(p0_q) && $stable(blk_lo_q) && $stable(blk_hi_q) && $stable(skip_q)));
endmodule

bind vpm_lane_pred_unit vpm_lane_pred_chk #(
  .LANES(LANES), .BLK_W(BLK_W), .SKIP_W(SKIP_W), .TSZ_W(TSZ_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_p0(wr_p0), .wr_skip(wr_skip),
  .retire(retire), .cond_nib(cond_nib), .lane_mask(lane_mask), .p0_q(p0_q),
  .blk_lo_q(blk_lo_q), .blk_hi_q(blk_hi_q), .skip_q(skip_q)
);

// File: tb/vpm_lane_pred_unit_test.sv
module vpm_lane_pred_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_p0 = '0;
  logic [3:0]  wr_blk_lo = '0, wr_blk_hi = '0;
  logic [2:0]  wr_skip = '0;
  logic        retire = 1'b0;
  logic [3:0]  cond_nib = 4'd1;
  logic [2:0]  tail_size = 3'd4;
  logic [31:0] loop_cnt = '0;
  logic [15:0] lane_mask, p0_q;
  logic [3:0]  blk_lo_q, blk_hi_q;
  logic [2:0]  skip_q;

  int tests = 0, fails = 0;
  bit done = 0;
  string tag = "R9";

  // behavioural reference state
  int m_p0 = 0, m_lo = 0, m_hi = 0, m_skip = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpm_lane_pred_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_p0(wr_p0), .wr_blk_lo(wr_blk_lo),
    .wr_blk_hi(wr_blk_hi), .wr_skip(wr_skip), .retire(retire), .cond_nib(cond_nib),
    .tail_size(tail_size), .loop_cnt(loop_cnt), .lane_mask(lane_mask), .p0_q(p0_q),
    .blk_lo_q(blk_lo_q), .blk_hi_q(blk_hi_q), .skip_q(skip_q)
  );

  function automatic int ref_mask();
    int m = m_p0;
    if (m_lo == 0) m = m | 'h00FF;
    if (m_hi == 0) m = m | 'hFF00;
    if (tail_size < 4 && loop_cnt <= (32'd16 >> tail_size))
      m = m & ((1 << (int'(loop_cnt) << tail_size)) - 1);
    if (cond_nib == 0) begin
      if (m_skip == 1) m = m & 'hFFF0;
      else if (m_skip == 2) m = m & 'hFF00;
      else if (m_skip == 3 || m_skip == 4) m = m & 'hF000;
    end
    return m & 'hFFFF;
  endfunction

  task automatic model_step();
    if (rst) begin
      m_p0 = 0; m_lo = 0; m_hi = 0; m_skip = 0;
    end else if (wr_en) begin
      m_p0 = wr_p0; m_lo = wr_blk_lo; m_hi = wr_blk_hi; m_skip = wr_skip;
    end else if (retire) begin
      if (cond_nib == 0) m_skip = (m_skip == 4) ? 1 : 0;
      if (m_lo != 0 || m_hi != 0) begin
        if (m_lo > 8) m_p0 = m_p0 ^ 'h00FF;
        if (m_hi > 8) m_p0 = m_p0 ^ 'hFF00;
        m_lo = (m_lo * 2) % 16;
        m_hi = (m_hi * 2) % 16;
      end
    end
  endtask

  task automatic check(string what, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // one clock: model follows the edge, compare on the falling edge
  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("lane_mask", int'(lane_mask), ref_mask());
    check("state", {p0_q, blk_lo_q, blk_hi_q, 5'(skip_q)},
          {16'(m_p0), 4'(m_lo), 4'(m_hi), 5'(m_skip)});
  endtask

  task automatic drive(bit w, int p0, int lo, int hi, int sk, bit ret, int cn, int ts, int cnt);
    wr_en = w; wr_p0 = 16'(p0); wr_blk_lo = 4'(lo); wr_blk_hi = 4'(hi);
    wr_skip = 3'(sk); retire = ret; cond_nib = 4'(cn); tail_size = 3'(ts);
    loop_cnt = 32'(cnt);
    cycle();
  endtask

  function automatic int rnz();
    return 1 + int'($urandom_range(14));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset state, mask all ones
    rst = 1'b1;
    repeat (3) cycle();
    rst = 1'b0;
    tag = "R9";
    drive(0, 0, 0, 0, 0, 0, 1, 4, 0);
    check("reset mask", int'(lane_mask), 'hFFFF);

    // R8: loads, and load beating retire
    tag = "R8";
    for (int i = 0; i < 20; i++)
      drive(1, int'($urandom), int'($urandom_range(15)), int'($urandom_range(15)),
            int'($urandom_range(4)), i % 2 == 1, int'($urandom_range(15)), 4, 0);

    // R1: block predication only
    tag = "R1";
    for (int i = 0; i < 40; i++) begin
      drive(1, int'($urandom), (i % 3 == 0) ? 0 : int'($urandom_range(15)),
            (i % 4 == 0) ? 0 : int'($urandom_range(15)), int'($urandom_range(4)),
            0, rnz(), 4 + int'($urandom_range(3)), int'($urandom_range(20)));
      drive(0, 0, 0, 0, 0, 0, rnz(), 4 + int'($urandom_range(3)), int'($urandom));
    end

    // R2: tail trimming around each size threshold
    tag = "R2";
    drive(1, 'hA5C3, 5, 9, 0, 0, 1, 4, 0);
    for (int ts = 0; ts < 6; ts++)
      for (int c = 0; c < 19; c++)
        drive(0, 0, 0, 0, 0, 0, rnz(), ts, c);
    drive(0, 0, 0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF);
    drive(0, 0, 0, 0, 0, 0, 1, 3, 0);
    check("cnt0 clears", int'(lane_mask), 0);

    // R3: beat removal, and no effect when the nibble is nonzero
    tag = "R3";
    for (int s = 0; s < 5; s++) begin
      drive(1, 'hFFFF, 0, 0, s, 0, 0, 4, 0);
      drive(0, 0, 0, 0, 0, 0, 0, 4, 0);
      drive(0, 0, 0, 0, 0, 0, rnz(), 4, 0);
      check("nibble nonzero ignores skip", int'(lane_mask), 'hFFFF);
    end

    // R4: skip collapse on retire
    tag = "R4";
    for (int s = 0; s < 5; s++) begin
      drive(1, int'($urandom), 0, 0, s, 0, 0, 4, 0);
      drive(0, 0, 0, 0, 0, 1, 0, 4, 0);
      drive(1, int'($urandom), 0, 0, s, 0, 0, 4, 0);
      drive(0, 0, 0, 0, 0, 1, rnz(), 4, 0);
    end

    // R5: retire with both fields zero
    tag = "R5";
    drive(1, 'h1234, 0, 0, 0, 0, 1, 4, 0);
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 0, 1, rnz(), 4, 0);

    // R6/R7: retire chains through boundary field values
    tag = "R6";
    for (int lo = 0; lo < 16; lo++) begin
      drive(1, int'($urandom), lo, 15 - lo, int'($urandom_range(4)), 0, 1, 4, 0);
      for (int k = 0; k < 5; k++) drive(0, 0, 0, 0, 0, 1, int'($urandom_range(3)), 4, 0);
    end
    tag = "R7";
    drive(1, 'h00FF, 8, 1, 0, 0, 1, 4, 0);
    for (int k = 0; k < 5; k++) drive(0, 0, 0, 0, 0, 1, 1, 4, 0);

    // R10: hold with neither strobe
    tag = "R10";
    drive(1, 'hBEEF, 12, 3, 4, 0, 1, 4, 0);
    for (int i = 0; i < 15; i++)
      drive(0, int'($urandom), int'($urandom_range(15)), int'($urandom_range(15)),
            int'($urandom_range(4)), 0, int'($urandom_range(15)),
            int'($urandom_range(7)), int'($urandom_range(20)));

    // mixed traffic
    tag = "R1";
    for (int i = 0; i < 400; i++)
      drive($urandom_range(3) == 0, int'($urandom), int'($urandom_range(15)),
            int'($urandom_range(15)), int'($urandom_range(4)), $urandom_range(1) == 1,
            ($urandom_range(1) == 1) ? 0 : int'($urandom_range(15)),
            int'($urandom_range(7)), int'($urandom_range(18)));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule